// File: doc/BRIEF.md
# Word-to-Bit Serializer with Forwarded Word Clock

The block turns a stream of 8-bit words into a single serial bit line running at eight times the word rate. It runs from one fast serial clock and derives a word clock from it by dividing by eight. That word clock leaves the block so that the upstream logic can launch its data on it. The upstream side returns the data with its own copy of the word clock, delayed by an unknown but bounded amount. The block captures each word on that returned clock. It then moves the word into the serial clock domain through a two-stage holding register, at fixed points of the divider count. A parallel load at the end of each word period hands the word to an output shift register. The shift register then sends the word most significant bit first.

There is no valid/ready handshake and no back-pressure. The block consumes exactly one word in every word period. The upstream side is paced by the forwarded word clock, so the returned clock takes the place of a valid strobe, and a word that is not replaced in time is simply sent again. At the nominal rate the serial clock is 622.08 MHz and the word clock is 77.76 MHz. The design is written for any power-of-two word width of at least 4.

Top module: `ser_tx_top`

## Requirements
- R1: `pclk_out` is the serial clock divided by eight. It is high for 4 serial cycles and low for 4, and it is held high while reset is active.
- R2: A word on `par_data` is captured only on the rising edge of `pclk_in`. Changes to `par_data` between rising edges of `pclk_in` do not reach the serial output.
- R3: Words are transferred correctly for any delay from 0 to 5 ns between a rising edge of `pclk_out` and the matching rising edge of `pclk_in`, with a serial period of 8 ns.
- R4: Each word occupies 8 consecutive serial bit periods and is sent bit 7 first and bit 0 last. The first bit, bit 7, starts on the serial clock edge on which `pclk_out` rises.
- R5: On every serial cycle except the load cycle, the shift register moves left by one place, shifts in 0, and its bit 7 drives `ser_out`.
- R6: The shift register loads once per word period, on the last divider count. It loads from the second stage of a holding register. The first stage samples the captured word at count 3 and the second stage samples the first at count 5, where count 0 is the cycle in which `pclk_out` rises.
- R7: While reset is active, `ser_out` is low and all registers are cleared. The two word periods that follow the first rise of `pclk_out` after reset carry all-zero words.
- R8: Latency is fixed. A word that is present on `par_data` at the rising edge of `pclk_in` in word period k is sent during word period k+1.
- R9: Every word period sends the next captured word. No word is dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_data | input | 8 | Parallel word, captured on the rising edge of `pclk_in` |
| pclk_in | input | 1 | Word clock returned by the upstream logic |
| pclk_out | output | 1 | Forwarded word clock, serial clock divided by eight |
| ser_out | output | 1 | Serial data, most significant bit first |

## Verification
On every cycle, the assertions check the following:
- the 4-cycle half periods of `pclk_out`;
- that each load is followed by a rising edge of `pclk_out`;
- that a load copies the holding register;
- the shift-by-one step on every other cycle;
- a low `ser_out` during reset.

Only the bench scenarios can show the rest. They cover capture on the returned clock across the whole skew range, rejection of data that changes after the capture edge, the two-period latency, and the absence of dropped or repeated words in long streams of varied patterns.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned SER_WORD_W_DEF = 8;

  // Divider count at which the first holding stage samples the captured word.
  function automatic int unsigned slot_hold_a(input int unsigned w);
    return w / 2 - 1;
  endfunction

  // Divider count at which the second holding stage samples the first.
  function automatic int unsigned slot_hold_b(input int unsigned w);
    return w - 3;
  endfunction

  // Divider count at which the shift register takes the held word.
  function automatic int unsigned slot_load(input int unsigned w);
    return w - 1;
  endfunction
endpackage

// File: rtl/ser_clkdiv.sv
module ser_clkdiv #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic pclk_out,
  output logic hold_a_en,
  output logic hold_b_en,
  output logic load_en
);
  localparam int unsigned CNT_W    = $clog2(WORD_W);
  localparam int unsigned SLOT_A   = ser_pkg::slot_hold_a(WORD_W);
  localparam int unsigned SLOT_B   = ser_pkg::slot_hold_b(WORD_W);
  localparam int unsigned SLOT_LD  = ser_pkg::slot_load(WORD_W);

  logic [CNT_W-1:0] cnt_q;

  // WORD_W is a power of two, so the counter wraps by itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // High for the first half of the word period, rising when the count wraps to 0.
  assign pclk_out  = ~cnt_q[CNT_W-1];
  assign hold_a_en = (cnt_q == CNT_W'(SLOT_A));
  assign hold_b_en = (cnt_q == CNT_W'(SLOT_B));
  assign load_en   = (cnt_q == CNT_W'(SLOT_LD));
endmodule

// File: rtl/ser_capture.sv
module ser_capture #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input  logic              pclk_in,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  // Input register in the returned word-clock domain.
  always_ff @(posedge pclk_in or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ser_holdsync.sv
module ser_holdsync #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_a,
  input  logic              en_b,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] stage_a;

  // Stage A samples the captured word only while it is known to be stable
  // (several serial cycles after the capture edge). Stage B decouples that
  // sample from the load into the shift register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= '0;
      q       <= '0;
    end else begin
      if (en_a) stage_a <= d;
      if (en_b) q       <= stage_a;
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] shift_q,
  output logic              ser_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shift_q <= '0;
    else if (load_en) shift_q <= d;
    else              shift_q <= {shift_q[WORD_W-2:0], 1'b0};
  end

  assign ser_out = shift_q[WORD_W-1];
endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input  logic              clk_ser,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] par_data,
  input  logic              pclk_in,
  output logic              pclk_out,
  output logic              ser_out
);
  logic              hold_a_en;
  logic              hold_b_en;
  logic              load_en;
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] hold_b;
  logic [WORD_W-1:0] shift_q;

  ser_clkdiv #(.WORD_W(WORD_W)) u_div (
    .clk       (clk_ser),
    .rst_n     (rst_n),
    .pclk_out  (pclk_out),
    .hold_a_en (hold_a_en),
    .hold_b_en (hold_b_en),
    .load_en   (load_en)
  );

  ser_capture #(.WORD_W(WORD_W)) u_cap (
    .pclk_in (pclk_in),
    .rst_n   (rst_n),
    .d       (par_data),
    .q       (cap_q)
  );

  ser_holdsync #(.WORD_W(WORD_W)) u_hold (
    .clk   (clk_ser),
    .rst_n (rst_n),
    .en_a  (hold_a_en),
    .en_b  (hold_b_en),
    .d     (cap_q),
    .q     (hold_b)
  );

  ser_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk     (clk_ser),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d       (hold_b),
    .shift_q (shift_q),
    .ser_out (ser_out)
  );
endmodule

// File: rtl/ser_tx_checks.sv
module ser_tx_checks #(
  parameter int unsigned WORD_W = ser_pkg::SER_WORD_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pclk_out,
  input logic              ser_out,
  input logic              load_en,
  input logic [WORD_W-1:0] shift_q,
  input logic [WORD_W-1:0] hold_q
);
  localparam int unsigned HALF  = WORD_W / 2;
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic             prev_pclk;
  logic             seen_edge;
  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pclk <= 1'b1;
      seen_edge <= 1'b0;
      run_len   <= '0;
    end else begin
      prev_pclk <= pclk_out;
      if (pclk_out != prev_pclk) begin
        run_len   <= '0;
        seen_edge <= 1'b1;
      end else begin
        run_len <= run_len + 1'b1;
      end
    end
  end

  AST_PCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && pclk_out != prev_pclk) |-> run_len == CNT_W'(HALF - 1)); // R1

  AST_LOAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> $rose(pclk_out)); // R4

  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> shift_q == $past(hold_q)); // R6

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (shift_q[WORD_W-1:1] == $past(shift_q[WORD_W-2:0])) && !shift_q[0]); // R5

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_LOW: assert (ser_out == 1'b0); // R7
    end
  end
endmodule

bind ser_tx_top ser_tx_checks #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk_ser),
  .rst_n    (rst_n),
  .pclk_out (pclk_out),
  .ser_out  (ser_out),
  .load_en  (load_en),
  .shift_q  (shift_q),
  .hold_q   (hold_b)
);

// File: tb/sim_ser_tx_top.sv
`timescale 1ns/1ps
module sim_ser_tx_top;
  logic       clk_ser = 1'b0;
  logic       rst_n   = 1'b0;
  logic [7:0] par_data = 8'h00;
  logic       pclk_in  = 1'b1;
  logic       pclk_out;
  logic       ser_out;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  real skew_ns = 0.0;
  logic [7:0] words [0:63];

  ser_tx_top u0 (
    .clk_ser  (clk_ser),
    .rst_n    (rst_n),
    .par_data (par_data),
    .pclk_in  (pclk_in),
    .pclk_out (pclk_out),
    .ser_out  (ser_out)
  );

  always #4 clk_ser = ~clk_ser;

  // Returned word clock: forwarded clock delayed by the skew under test.
  always @(pclk_out) pclk_in <= #(skew_ns) pclk_out;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int kind, input int i);
    case (kind)
      0: return 8'(i + 1);
      1: return 8'h01 << (i % 8);
      2: begin
        case (i % 4)
          0: return 8'hA5;
          1: return 8'h5A;
          2: return 8'hFF;
          default: return 8'h00;
        endcase
      end
      default: return 8'(i * 37 + 11);
    endcase
  endfunction

  task automatic do_reset(input real skew);
    rst_n    = 1'b0;
    par_data = 8'h00;
    skew_ns  = skew;
    repeat (4) @(negedge clk_ser);
    rst_n = 1'b1;
  endtask

  // R7, R1: state held during reset
  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_ser);
    check("R7 ser_out low in reset", {7'd0, ser_out}, 8'h00);
    check("R1 pclk_out high in reset", {7'd0, pclk_out}, 8'h01);
    rst_n = 1'b1;
  endtask

  // R1: divide by eight, 4 high and 4 low
  task automatic t_ratio;
    int hi;
    int per;
    do_reset(0.0);
    @(posedge pclk_out);
    hi = 0;
    per = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_ser);
      per++;
      if (pclk_out) hi++;
    end
    check("R1 high cycles per word period", 8'(hi), 8'd4);
    @(negedge clk_ser);
    check("R1 pclk_out rises after 8 cycles", {7'd0, pclk_out}, 8'h01);
    check("R1 period length", 8'(per), 8'd8);
  endtask

  // R2 R3 R4 R7 R8 R9: stream n words at a given skew
  task automatic t_stream(input real skew, input int kind, input int n, input bit junk);
    logic [7:0] rx;
    logic [7:0] exp;
    for (int k = 0; k < n; k++) words[k] = gen(kind, k);
    do_reset(skew);
    for (int p = 0; p < n + 2; p++) begin
      @(posedge pclk_out);
      rx = 8'h00;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk_ser);
        rx = {rx[6:0], ser_out};
        // junk after the capture edge must be ignored (R2)
        if (i == 1 && junk) par_data = ~((p < n) ? words[p] : 8'h00) ^ 8'h3C;
        if (i == 4) par_data = (p < n) ? words[p] : 8'h00;
      end
      exp = (p < 2) ? 8'h00 : words[p-2];
      if (p < 2) check("R7 zero words after reset", rx, exp);
      else if (junk) check("R2 capture on pclk_in rise only", rx, exp);
      else check("R3 R4 R8 R9 stream word", rx, exp);
    end
  endtask

  // R3: sweep the returned-clock delay over 0..5 ns
  task automatic t_skew_sweep;
    for (int s = 0; s <= 10; s++) t_stream(s * 0.5, 3 - (s % 4), 12, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ratio();
    t_stream(0.0, 0, 40, 1'b0);
    t_stream(2.5, 1, 24, 1'b0);
    t_stream(5.0, 2, 24, 1'b0);
    t_stream(0.0, 3, 16, 1'b1);
    t_stream(5.0, 0, 16, 1'b1);
    t_skew_sweep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule